// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block fetches a translation from a two-level table in memory after the translation cache misses. It accepts a miss made of a virtual page number and the upper bits of the table base, then reads a 32-bit first-level descriptor through a simple request/acknowledge and response-valid memory port. The low two bits of that word decide what happens next. A section descriptor finishes the walk at once. A page-table descriptor starts a second read. An invalid or reserved code ends the walk with a fault.

A walk ends with a one-cycle report. A refill report carries the physical base, a size code, the domain, the access-permission bits, and the cacheable and bufferable bits. A fault report carries the fault level and the domain. Permission checks and storage of the result are done by the cache that sits next to this block.

Top module: `xlat_table_walker`

## Requirements
- R1: After reset `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: The first read goes to address {tbl_base_hi[17:0], miss_vpn[19:8], 2'b00}. This is base bits 31:14, then virtual address bits 31:20, then two zero bits.
- R3: `mem_req_valid` stays high with a stable `mem_req_addr` until the cycle in which `mem_req_ready` is 1. It then drops. A response is taken only after the request has been acknowledged.
- R4: First-level type 2'b10 (section) ends the walk with no second read. The refill then has pbase = {d[31:20], 20'b0}, size code 0, ap = d[11:10], domain = d[8:5], c = d[3] and b = d[2].
- R5: First-level type 2'b01 (page table) issues a second read at {d[31:10], va[19:12], 2'b00}.
- R6: At the second level, type 2'b01 gives a large page: pbase = {d2[31:16], 16'b0} and size code 1. Type 2'b10 gives a small page: pbase = {d2[31:12], 12'b0} and size code 2. For both, ap = d2[5:4], c = d2[3], b = d2[2], and the domain comes from bits 8:5 of the first-level descriptor.
- R7: First-level type 2'b00 or 2'b11 reports a fault with `fault_page` = 0 and domain d[8:5], and issues no second read.
- R8: Second-level type 2'b00 or 2'b11 reports a fault with `fault_page` = 1 and the first-level domain.
- R9: `miss_ready` is 1 only while idle. A `miss_valid` pulse during a walk is ignored and does not change the addresses read.
- R10: Each walk gives exactly one report that lasts one cycle. `refill_valid` and `fault_valid` are never high together, and `miss_ready` is high again in the cycle after the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base_hi | input | 18 | Table base bits 31:14 |
| miss_valid | input | 1 | Miss request |
| miss_vpn | input | 20 | Virtual address bits 31:12 of the miss |
| miss_ready | output | 1 | Walker idle, miss accepted |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Word-aligned descriptor address |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| refill_valid | output | 1 | One-cycle refill report |
| refill_pbase | output | 32 | Physical base of mapping |
| refill_size | output | 2 | 0 section, 1 large page, 2 small page |
| refill_ap | output | 2 | Access-permission bits |
| refill_c | output | 1 | Cacheable |
| refill_b | output | 1 | Bufferable |
| refill_domain | output | 4 | Domain of mapping |
| fault_valid | output | 1 | One-cycle fault report |
| fault_page | output | 1 | 0 first-level fault, 1 second-level fault |
| fault_domain | output | 4 | Domain reported with the fault |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 16kB-aligned table, 1MB sections, 64kB large pages and 4kB small pages. With these values every descriptor field sits at the bit position the requirements name, so the bench models can predict each address and result field bit for bit. Because the virtual page number and base are full width, the all-ones and all-zero index corners are reachable. All four type codes can be driven at both levels. Random acknowledge and response latencies, including zero, exercise the hold and wait states.

// File: rtl/xw_pkg.sv
// Shared types and descriptor field positions for the table walker.
// Assumes 32-bit descriptors laid out as described in the brief.
package xw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_REPORT
    } walk_state_t;

    typedef enum logic [1:0] {
        MAP_SECTION = 2'd0,
        MAP_LARGE   = 2'd1,
        MAP_SMALL   = 2'd2
    } map_size_t;

    typedef enum logic [1:0] {
        K_FAULT = 2'd0,
        K_NEXT  = 2'd1,
        K_LEAF  = 2'd2
    } desc_kind_t;

    localparam int DESC_W    = 32;
    localparam int DOM_W     = 4;
    localparam int DOM_LO    = 5;
    localparam int L1_AP_LO  = 10;
    localparam int L2_AP_LO  = 4;
    localparam int C_BIT     = 3;
    localparam int B_BIT     = 2;
endpackage

// File: rtl/xw_addr_gen.sv
// Forms the first- and second-level descriptor addresses.
// Assumes base, table index and two zero bits fill PA_W exactly.
module xw_addr_gen #(
    parameter int PA_W         = 32,
    parameter int VA_W         = 32,
    parameter int TBL_ALIGN    = 14,
    parameter int SECT_SHIFT   = 20,
    parameter int PAGE_SHIFT   = 12,
    parameter int L2BASE_SHIFT = 10
) (
    input  logic [PA_W-1:TBL_ALIGN]    base_hi,
    input  logic [VA_W-1:PAGE_SHIFT]   vpn,
    input  logic [PA_W-1:L2BASE_SHIFT] l2_base,
    output logic [PA_W-1:0]            l1_addr,
    output logic [PA_W-1:0]            l2_addr
);
    // Concatenate base and index fields into word addresses
    always_comb begin
        l1_addr = {base_hi, vpn[VA_W-1:SECT_SHIFT], 2'b00};
        l2_addr = {l2_base, vpn[SECT_SHIFT-1:PAGE_SHIFT], 2'b00};
    end
endmodule

// File: rtl/xw_l1_decode.sv
// Decodes a first-level descriptor into kind and section fields.
// Types 00 and 11 both map to a fault.
module xw_l1_decode
    import xw_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int SECT_SHIFT = 20
) (
    input  logic [DESC_W-1:0] desc,
    output desc_kind_t        kind,
    output logic [PA_W-1:0]   sect_base,
    output logic [DOM_W-1:0]  domain,
    output logic [1:0]        ap,
    output logic              c,
    output logic              b
);
    logic unused_l1_bits;
    assign unused_l1_bits = ^{desc[9], desc[4]};

    // Classify the type code and pull the section fields
    always_comb begin
        unique case (desc[1:0])
            2'b10:   kind = K_LEAF;
            2'b01:   kind = K_NEXT;
            default: kind = K_FAULT;
        endcase
        sect_base = {desc[DESC_W-1:SECT_SHIFT], {SECT_SHIFT{1'b0}}};
        domain    = desc[DOM_LO +: DOM_W];
        ap        = desc[L1_AP_LO +: 2];
        c         = desc[C_BIT];
        b         = desc[B_BIT];
    end
endmodule

// File: rtl/xw_l2_decode.sv
// Decodes a second-level descriptor into kind, size and page fields.
// Types 00 and 11 both map to a fault.
module xw_l2_decode
    import xw_pkg::*;
#(
    parameter int PA_W        = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int LARGE_SHIFT = 16
) (
    input  logic [DESC_W-1:0] desc,
    output desc_kind_t        kind,
    output map_size_t         size,
    output logic [PA_W-1:0]   page_base,
    output logic [1:0]        ap,
    output logic              c,
    output logic              b
);
    logic unused_l2_bits;
    assign unused_l2_bits = ^desc[11:6];

    // Classify the type code and select the page base by size
    always_comb begin
        kind      = K_FAULT;
        size      = MAP_SMALL;
        page_base = {desc[DESC_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        unique case (desc[1:0])
            2'b01: begin
                kind      = K_LEAF;
                size      = MAP_LARGE;
                page_base = {desc[DESC_W-1:LARGE_SHIFT], {LARGE_SHIFT{1'b0}}};
            end
            2'b10: kind = K_LEAF;
            default: kind = K_FAULT;
        endcase
        ap = desc[L2_AP_LO +: 2];
        c  = desc[C_BIT];
        b  = desc[B_BIT];
    end
endmodule

// File: rtl/xlat_table_walker.sv
// Walk control: accepts a miss while idle, performs one or two
// descriptor reads and emits a one-cycle refill or fault report.
// Assumes memory answers each acknowledged read with one response.
module xlat_table_walker
    import xw_pkg::*;
#(
    parameter int PA_W         = 32,
    parameter int VA_W         = 32,
    parameter int TBL_ALIGN    = 14,
    parameter int SECT_SHIFT   = 20,
    parameter int LARGE_SHIFT  = 16,
    parameter int PAGE_SHIFT   = 12,
    parameter int L2BASE_SHIFT = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PA_W-TBL_ALIGN-1:0] tbl_base_hi,
    input  logic                      miss_valid,
    input  logic [VA_W-PAGE_SHIFT-1:0] miss_vpn,
    output logic                      miss_ready,
    output logic                      mem_req_valid,
    output logic [PA_W-1:0]           mem_req_addr,
    input  logic                      mem_req_ready,
    input  logic                      mem_rsp_valid,
    input  logic [DESC_W-1:0]         mem_rsp_data,
    output logic                      refill_valid,
    output logic [PA_W-1:0]           refill_pbase,
    output logic [1:0]                refill_size,
    output logic [1:0]                refill_ap,
    output logic                      refill_c,
    output logic                      refill_b,
    output logic [DOM_W-1:0]          refill_domain,
    output logic                      fault_valid,
    output logic                      fault_page,
    output logic [DOM_W-1:0]          fault_domain
);
    localparam int VPN_W = VA_W - PAGE_SHIFT;

    walk_state_t       state_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PA_W-1:0]   addr_q;
    logic [PA_W-1:0]   base_q;
    map_size_t         size_q;
    logic [DOM_W-1:0]  dom_q;
    logic [1:0]        ap_q;
    logic              c_q, b_q, fault_q, page_q;

    logic [VPN_W-1:0]  vpn_sel;
    logic [PA_W-1:0]   l1_addr, l2_addr;
    desc_kind_t        l1_kind, l2_kind;
    logic [PA_W-1:0]   l1_base, l2_base;
    logic [DOM_W-1:0]  l1_dom;
    logic [1:0]        l1_ap, l2_ap;
    logic              l1_c, l1_b, l2_c, l2_b;
    map_size_t         l2_size;

    // Use the incoming page number while idle, the held one otherwise
    assign vpn_sel = (state_q == ST_IDLE) ? miss_vpn : vpn_q;

    xw_addr_gen #(
        .PA_W(PA_W), .VA_W(VA_W), .TBL_ALIGN(TBL_ALIGN),
        .SECT_SHIFT(SECT_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
        .L2BASE_SHIFT(L2BASE_SHIFT)
    ) i_addr (
        .base_hi (tbl_base_hi),
        .vpn     (vpn_sel),
        .l2_base (mem_rsp_data[PA_W-1:L2BASE_SHIFT]),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    xw_l1_decode #(.PA_W(PA_W), .SECT_SHIFT(SECT_SHIFT)) i_l1 (
        .desc (mem_rsp_data), .kind (l1_kind), .sect_base (l1_base),
        .domain (l1_dom), .ap (l1_ap), .c (l1_c), .b (l1_b)
    );

    xw_l2_decode #(
        .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
    ) i_l2 (
        .desc (mem_rsp_data), .kind (l2_kind), .size (l2_size),
        .page_base (l2_base), .ap (l2_ap), .c (l2_c), .b (l2_b)
    );

    // Walk sequencer and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            addr_q  <= '0;
            base_q  <= '0;
            size_q  <= MAP_SECTION;
            dom_q   <= '0;
            ap_q    <= '0;
            c_q     <= 1'b0;
            b_q     <= 1'b0;
            fault_q <= 1'b0;
            page_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (miss_valid) begin
                    vpn_q   <= miss_vpn;
                    addr_q  <= l1_addr;
                    state_q <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    dom_q <= l1_dom;
                    unique case (l1_kind)
                        K_LEAF: begin
                            base_q  <= l1_base;
                            size_q  <= MAP_SECTION;
                            ap_q    <= l1_ap;
                            c_q     <= l1_c;
                            b_q     <= l1_b;
                            fault_q <= 1'b0;
                            state_q <= ST_REPORT;
                        end
                        K_NEXT: begin
                            addr_q  <= l2_addr;
                            state_q <= ST_L2_REQ;
                        end
                        default: begin
                            fault_q <= 1'b1;
                            page_q  <= 1'b0;
                            state_q <= ST_REPORT;
                        end
                    endcase
                end
                ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (l2_kind == K_LEAF) begin
                        base_q  <= l2_base;
                        size_q  <= l2_size;
                        ap_q    <= l2_ap;
                        c_q     <= l2_c;
                        b_q     <= l2_b;
                        fault_q <= 1'b0;
                    end else begin
                        fault_q <= 1'b1;
                        page_q  <= 1'b1;
                    end
                    state_q <= ST_REPORT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive handshake and report outputs from state
    always_comb begin
        miss_ready    = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        mem_req_addr  = addr_q;
        refill_valid  = (state_q == ST_REPORT) && !fault_q;
        fault_valid   = (state_q == ST_REPORT) && fault_q;
        refill_pbase  = base_q;
        refill_size   = size_q;
        refill_ap     = ap_q;
        refill_c      = c_q;
        refill_b      = b_q;
        refill_domain = dom_q;
        fault_page    = page_q;
        fault_domain  = dom_q;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);
    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || refill_valid || fault_valid) |-> !miss_ready);
    assert_one_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && fault_valid));
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault_valid) |=> !(refill_valid || fault_valid) && miss_ready);
endmodule

// File: tb/test_xlat_table_walker.sv
module test_xlat_table_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] tbl_base_hi = '0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic        miss_ready, mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid, refill_c, refill_b, fault_valid, fault_page;
    logic [31:0] refill_pbase;
    logic [1:0]  refill_size, refill_ap;
    logic [3:0]  refill_domain, fault_domain;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    xlat_table_walker i_xlat_table_walker (
        .clk, .rst_n, .tbl_base_hi, .miss_valid, .miss_vpn, .miss_ready,
        .mem_req_valid, .mem_req_addr, .mem_req_ready, .mem_rsp_valid,
        .mem_rsp_data, .refill_valid, .refill_pbase, .refill_size,
        .refill_ap, .refill_c, .refill_b, .refill_domain, .fault_valid,
        .fault_page, .fault_domain
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_l1_addr(input logic [17:0] bh, input logic [19:0] vpn);
        return {bh, vpn[19:8], 2'b00};
    endfunction

    function automatic logic [31:0] ref_l2_addr(input logic [31:0] d, input logic [19:0] vpn);
        return {d[31:10], vpn[7:0], 2'b00};
    endfunction

    // Serve one read: check address, hold off ack, then return data
    task automatic serve(input string tag, input logic [31:0] exp_addr,
                         input logic [31:0] data, input int la, input int lr);
        int n = 0;
        while (!mem_req_valid && n < 10) begin @(negedge clk); n++; end
        chk({tag, " request address"}, mem_req_addr, exp_addr);
        for (int i = 0; i < la; i++) begin
            @(negedge clk);
            chk("R3 request held", {31'b0, mem_req_valid}, 32'd1);
            chk("R3 address stable", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R3 request dropped", {31'b0, mem_req_valid}, 32'd0);
        for (int i = 0; i < lr; i++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = $urandom;
    endtask

    task automatic walk(input logic [19:0] vpn, input logic [17:0] bh,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int la, input int lr, input bit poke);
        bit two = (d1[1:0] == 2'b01);
        bit flt;
        bit pg;
        string tg;
        logic [31:0] eb;
        logic [1:0] es, eap;
        logic [3:0] ed;
        logic ec, eb_bit;
        int n = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; tbl_base_hi = bh;
        @(negedge clk);
        miss_valid = 1'b0;
        if (poke) begin
            chk("R9 busy not ready", {31'b0, miss_ready}, 32'd0);
            miss_valid = 1'b1; miss_vpn = ~vpn; tbl_base_hi = ~bh;
            @(negedge clk);
            miss_valid = 1'b0;
        end
        serve("R2", ref_l1_addr(bh, vpn), d1, la, lr);
        if (two) serve("R5", ref_l2_addr(d1, vpn), d2, lr, la);
        // Expected report from the requirement text
        ed = d1[8:5];
        if (!two) begin
            flt = (d1[1:0] != 2'b10); pg = 1'b0;
            tg = flt ? "R7" : "R4";
            eb = {d1[31:20], 20'b0}; es = 2'd0; eap = d1[11:10];
            ec = d1[3]; eb_bit = d1[2];
        end else begin
            flt = (d2[1:0] == 2'b00) || (d2[1:0] == 2'b11); pg = 1'b1;
            tg = flt ? "R8" : "R6";
            eb = (d2[1:0] == 2'b01) ? {d2[31:16], 16'b0} : {d2[31:12], 12'b0};
            es = (d2[1:0] == 2'b01) ? 2'd1 : 2'd2;
            eap = d2[5:4]; ec = d2[3]; eb_bit = d2[2];
        end
        while (!(refill_valid || fault_valid) && n < 8) begin @(negedge clk); n++; end
        chk({tg, " kind (R10 one report)"}, {29'b0, refill_valid, fault_valid, 1'b0},
            {29'b0, !flt, flt, 1'b0});
        chk({tg, " no further read"}, {31'b0, mem_req_valid}, 32'd0);
        if (flt) begin
            chk({tg, " fault level"}, {31'b0, fault_page}, {31'b0, pg});
            chk({tg, " fault domain"}, {28'b0, fault_domain}, {28'b0, ed});
        end else begin
            chk({tg, " pbase"}, refill_pbase, eb);
            chk({tg, " size"}, {30'b0, refill_size}, {30'b0, es});
            chk({tg, " ap/c/b"}, {28'b0, refill_ap, refill_c, refill_b},
                {28'b0, eap, ec, eb_bit});
            chk({tg, " domain"}, {28'b0, refill_domain}, {28'b0, ed});
        end
        @(negedge clk);
        chk("R10 single-cycle report", {30'b0, refill_valid, fault_valid}, 32'd0);
        chk("R10 idle after report", {31'b0, miss_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset miss_ready", {31'b0, miss_ready}, 32'd1);
        chk("R1 reset outputs", {29'b0, mem_req_valid, refill_valid, fault_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {28'b0, miss_ready, mem_req_valid, refill_valid, fault_valid},
            32'b1000);
        // Directed corners
        walk(20'hFFFFF, 18'h3FFFF, 32'hFFF0_0DEE, 32'h0, 0, 0, 0);            // R4 section, all ones
        walk(20'h00000, 18'h00000, 32'h1234_5C2A, 32'h0, 3, 2, 1);            // R4 with busy poke R9
        walk(20'hABCDE, 18'h15555, 32'h8765_41E1, 32'hCAFE_B03D, 1, 1, 0);    // R5/R6 large
        walk(20'h13579, 18'h2AAAA, 32'h0000_0001, 32'hFFFF_F0FE, 0, 4, 1);    // R6 small
        walk(20'h24680, 18'h01234, 32'hFFFF_FDE0, 32'h0, 2, 0, 0);            // R7 type 00
        walk(20'h11111, 18'h3C3C3, 32'h5555_55B3, 32'h0, 0, 0, 0);            // R7 type 11
        walk(20'h22222, 18'h00FF0, 32'hAAAA_A8C1, 32'h1234_5670, 1, 2, 0);    // R8 type 00
        walk(20'h33333, 18'h0F0F0, 32'h0F0F_0F21, 32'hFFFF_FFFF, 2, 1, 0);    // R8 type 11
        // Random walks
        for (int i = 0; i < 120; i++)
            walk($urandom, $urandom, $urandom, $urandom,
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule